// File: doc/BRIEF.md
# Serial Byte Receiver with Framing Check

This block recovers bytes from an asynchronous serial line. A frame starts with a low start bit. Eight data bits follow, least significant bit first. A high stop bit closes the frame, and there is no parity bit. The line rests high between frames. Two parameters set the system clock frequency and the line rate. The block divides one by the other to get the number of clock cycles in one bit period.

The serial input passes through a two-flop synchroniser before any edge detection. A falling edge on the synchronised line opens a frame. The receiver checks the line again half a bit period later to confirm the start bit. It then samples each data bit at its centre and checks the stop bit at its centre. A good frame loads the byte onto the data output and raises a one-cycle done strobe. A bad start bit or a bad stop bit raises a one-cycle error strobe instead. While the enable input is low the receiver stays idle and drops any frame in progress.

Top module: `uart_rx_frame`

## Requirements
- R1: On a valid frame, `rx_byte` takes the eight data bits. The first data bit on the line lands in bit 0 and the last in bit 7. A start bit is low (0) and a stop bit is high (1).
- R2: `byte_valid` is high for exactly one clock cycle per valid frame. It is never high for two cycles in a row.
- R3: `rx_active` is high from an accepted falling edge until the frame ends, whether it ends well or in an error. It is low when the receiver is idle, and low in any cycle where `byte_valid` or `frame_err` is high.
- R4: If the stop bit is sampled low, `frame_err` pulses for one cycle, `byte_valid` stays low and `rx_byte` keeps its previous value. The two strobes are never high in the same cycle.
- R5: If the line is high again half a bit period after the falling edge, the start bit is rejected. `frame_err` pulses for one cycle, and the receiver returns to idle without receiving data.
- R6: While `rx_enable` is low, `rx_active`, `byte_valid` and `frame_err` are low from the following cycle on. `rx_byte` holds its value. Dropping `rx_enable` during a frame abandons that frame without any strobe.
- R7: A frame begins only on a high-to-low transition of the synchronised line. A line that is already low when the receiver is idle and enabled starts nothing.
- R8: One bit period lasts CLK_HZ/BAUD clock cycles. Frames sent at that rate are received correctly.
- R9: After reset, `rx_byte` is 0 and `byte_valid`, `frame_err` and `rx_active` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_in | input | 1 | Asynchronous serial line, idle high |
| rx_enable | input | 1 | High to allow reception |
| rx_byte | output | 8 | Last byte received in a valid frame |
| byte_valid | output | 1 | One-cycle strobe on a valid frame |
| rx_active | output | 1 | High while a frame is being received |
| frame_err | output | 1 | One-cycle strobe on a bad start or stop bit |

## Verification
The enable input and the completion of a frame can act in the same stretch of cycles. The bench sends a correct frame and pulls `rx_enable` low inside the stop bit, before the centre sample. The sample and the enable drop then meet at that point. The result is correct if neither strobe appears and `rx_byte` keeps its older value. A later correct frame must still be received, which shows the receiver has started again from idle.

// File: rtl/uart_rx_frame.sv
module uart_rx_frame #(
  parameter int CLK_HZ = 200_000_000,
  parameter int BAUD   = 12_500_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ser_in,
  input  logic       rx_enable,
  output logic [7:0] rx_byte,
  output logic       byte_valid,
  output logic       rx_active,
  output logic       frame_err
);
  localparam int BIT_TICKS  = CLK_HZ / BAUD;
  localparam int HALF_TICKS = BIT_TICKS / 2;
  localparam int CW         = $clog2(BIT_TICKS + 1);
  localparam logic [CW-1:0] BIT_LAST  = CW'(BIT_TICKS - 1);
  localparam logic [CW-1:0] HALF_LAST = CW'(HALF_TICKS - 1);

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} state_t;

  state_t        state;
  logic [2:0]    sync;
  logic [CW-1:0] cnt;
  logic [2:0]    idx;
  logic [7:0]    shreg;

  wire line = sync[1];
  wire fall = sync[2] & ~sync[1];

  assign rx_active = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      sync       <= 3'b111;
      cnt        <= '0;
      idx        <= '0;
      shreg      <= '0;
      rx_byte    <= '0;
      byte_valid <= 1'b0;
      frame_err  <= 1'b0;
    end else begin
      sync       <= {sync[1:0], ser_in};
      byte_valid <= 1'b0;
      frame_err  <= 1'b0;
      if (!rx_enable) begin
        state <= S_IDLE;
        cnt   <= '0;
      end else begin
        case (state)
          S_IDLE: begin
            cnt <= '0;
            if (fall) state <= S_START;
          end
          S_START: begin
            if (cnt == HALF_LAST) begin
              cnt <= '0;
              idx <= '0;
              if (line) begin
                frame_err <= 1'b1;
                state     <= S_IDLE;
              end else begin
                state <= S_DATA;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_DATA: begin
            if (cnt == BIT_LAST) begin
              cnt   <= '0;
              shreg <= {line, shreg[7:1]};
              if (idx == 3'd7) state <= S_STOP;
              idx <= idx + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_STOP: begin
            if (cnt == BIT_LAST) begin
              cnt   <= '0;
              state <= S_IDLE;
              if (line) begin
                rx_byte    <= shreg;
                byte_valid <= 1'b1;
              end else begin
                frame_err <= 1'b1;
              end
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

module uart_rx_frame_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_enable,
  input logic [7:0] rx_byte,
  input logic       byte_valid,
  input logic       rx_active,
  input logic       frame_err
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> !byte_valid); // R2
  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !frame_err); // R4
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(byte_valid && frame_err)); // R4
  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !byte_valid |-> $stable(rx_byte)); // R1
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_enable |=> (!rx_active && !byte_valid && !frame_err)); // R6
  AST_IDLE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid || frame_err) |-> !rx_active); // R3
endmodule

bind uart_rx_frame uart_rx_frame_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .rx_byte(rx_byte),
  .byte_valid(byte_valid), .rx_active(rx_active), .frame_err(frame_err)
);

// File: tb/test_uart_rx_frame.sv
`timescale 1ns/1ps
module test_uart_rx_frame;
  localparam int CLK_HZ = 200_000_000;
  localparam int BAUD   = 12_500_000;
  localparam int BITC   = CLK_HZ / BAUD;

  logic clk = 0, rst_n = 0, ser_in = 1, rx_enable = 0;
  logic [7:0] rx_byte;
  logic byte_valid, rx_active, frame_err;

  int checks = 0, failures = 0;
  int n_done = 0, n_err = 0, run = 0, max_run = 0, busy_cycles = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  uart_rx_frame #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) i_uart_rx_frame (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .rx_enable(rx_enable),
    .rx_byte(rx_byte), .byte_valid(byte_valid), .rx_active(rx_active),
    .frame_err(frame_err));

  always @(posedge clk) begin
    if (byte_valid) n_done++;
    if (frame_err) n_err++;
    if (rx_active) busy_cycles++;
    if (byte_valid || frame_err) run++; else run = 0;
    if (run > max_run) max_run = run;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic stop_lvl);
    ser_in = 0; wait_cyc(BITC);
    for (int i = 0; i < 8; i++) begin ser_in = d[i]; wait_cyc(BITC); end
    ser_in = stop_lvl; wait_cyc(BITC);
    ser_in = 1; wait_cyc(BITC);
  endtask

  task automatic t_reset;
    chk("R9 rx_byte", rx_byte, 0);
    chk("R9 strobes", {byte_valid, frame_err}, 0);
    chk("R9 rx_active", rx_active, 0);
  endtask

  task automatic t_good(input logic [7:0] d);
    int d0 = n_done, e0 = n_err;
    send(d, 1'b1);
    chk("R1 byte", rx_byte, d);
    chk("R2 R8 one done", n_done - d0, 1);
    chk("R4 no err on good frame", n_err - e0, 0);
  endtask

  task automatic t_busy;
    int b;
    ser_in = 0; wait_cyc(BITC);
    for (int i = 0; i < 8; i++) begin
      ser_in = i[0]; wait_cyc(BITC);
      if (i == 3) b = rx_active;
    end
    ser_in = 1; wait_cyc(2 * BITC);
    chk("R3 busy mid frame", b, 1);
    chk("R3 idle after frame", rx_active, 0);
    chk("R1 pattern 0xAA", rx_byte, 8'hAA);
  endtask

  task automatic t_stop_err;
    logic [7:0] prev = rx_byte;
    int d0 = n_done, e0 = n_err;
    send(8'h3C, 1'b0);
    chk("R4 err on low stop", n_err - e0, 1);
    chk("R4 no done", n_done - d0, 0);
    chk("R4 byte held", rx_byte, prev);
  endtask

  task automatic t_start_glitch;
    logic [7:0] prev = rx_byte;
    int d0 = n_done, e0 = n_err;
    ser_in = 0; wait_cyc(3);
    ser_in = 1; wait_cyc(2 * BITC);
    chk("R5 err on false start", n_err - e0, 1);
    chk("R5 no done", n_done - d0, 0);
    chk("R5 idle", rx_active, 0);
    chk("R5 byte held", rx_byte, prev);
  endtask

  task automatic t_disabled;
    logic [7:0] prev = rx_byte;
    int d0 = n_done, e0 = n_err, b0;
    rx_enable = 0; wait_cyc(2);
    b0 = busy_cycles;
    send(8'h5A, 1'b1);
    chk("R6 no strobes when off", (n_done - d0) + (n_err - e0), 0);
    chk("R6 never busy when off", busy_cycles - b0, 0);
    chk("R6 byte held when off", rx_byte, prev);
    rx_enable = 1; wait_cyc(2);
  endtask

  task automatic t_en_drop;
    logic [7:0] prev = rx_byte;
    int d0 = n_done, e0 = n_err;
    ser_in = 0; wait_cyc(BITC);
    for (int i = 0; i < 8; i++) begin ser_in = 1'b1; wait_cyc(BITC); end
    ser_in = 1; wait_cyc(4);
    rx_enable = 0; wait_cyc(BITC);
    chk("R6 drop in stop: no strobe", (n_done - d0) + (n_err - e0), 0);
    chk("R6 drop in stop: byte held", rx_byte, prev);
    chk("R6 drop: idle", rx_active, 0);
    rx_enable = 1; wait_cyc(4);
    t_good(8'h81);
  endtask

  task automatic t_fresh_edge;
    int d0 = n_done, e0 = n_err, b0;
    rx_enable = 0; ser_in = 0; wait_cyc(8);
    b0 = busy_cycles;
    rx_enable = 1; wait_cyc(3 * BITC);
    chk("R7 low line no start", busy_cycles - b0, 0);
    chk("R7 no strobes", (n_done - d0) + (n_err - e0), 0);
    ser_in = 1; wait_cyc(BITC);
    t_good(8'h7E);
  endtask

  initial begin
    wait_cyc(5);
    rst_n = 1; wait_cyc(2);
    t_reset();
    rx_enable = 1; wait_cyc(4);
    t_good(8'hA5);
    t_good(8'h00);
    t_good(8'hFF);
    t_good(8'h01);
    t_good(8'h80);
    t_busy();
    t_stop_err();
    t_good(8'h3C);
    t_start_glitch();
    t_disabled();
    t_en_drop();
    t_fresh_edge();
    chk("R2 R4 strobe width", max_run, 1);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule